// File: doc/BRIEF.md
# Buffered Page Write Sequencer

This block turns one byte-addressed write request of any length into the command frames that a buffered serial flash needs to store it. It cuts the request at page boundaries. For a chunk that covers only part of a page, it first has the device copy that page into its on-chip buffer, so the bytes the write does not touch survive. It then programs the chunk through the buffer. When verify is enabled, it has the device compare the buffer with the page and stops on a mismatch. After every command it polls the device status until the device reports ready.

Data comes from the host over a valid/ready byte stream. Data goes out through a byte-level valid/ready port to an external serial shifter, which owns chip select. A byte flagged as frame end closes the chip-select frame once it has been shifted. The host stream has back-pressure both ways. `in_ready` is high only while program data is due and the shifter is ready. When `in_valid` is low in that phase, `sp_valid` is low, so the shifter stalls instead of sending filler. Command and status bytes never wait on the host.

Top module: `pws_page_writer`

## Requirements
- R1: While reset is held and after it is released, `wr_busy`, `wr_done`, `sp_valid` and `in_ready` are low.
- R2: The first chunk is the smaller of the length and the bytes left to the end of the start page. Every later chunk is a full page, or the remainder if that is smaller. Each chunk is programmed exactly once, in address order.
- R3: A chunk shorter than `PAGE_BYTES` is preceded by a frame of four bytes: 0x53, then the page's device address with its low byte zero. A ready poll follows that frame. A full-page chunk gets no such frame.
- R4: Each chunk is programmed in one frame. The frame holds 0x82, then three address bytes, most significant first, equal to (page index << `PAGE_SHIFT`) + offset, then the chunk's data bytes. The end flag sits on the last data byte.
- R5: After each command frame, the block sends status frames (0xD7 followed by one dummy byte). It repeats them until bit 7 of the byte received in the dummy slot is 1, and it sends no other command until then.
- R6: With `wr_verify` set, each program is followed by a frame of 0x60 and the page address with its low byte zero, then a ready poll. If bit 6 of the ready status byte is 1, the write stops with `wr_err` = 2 and no further chunk is sent.
- R7: If `wr_addr + wr_len` exceeds `PAGE_BYTES*NUM_PAGES`, no frame is sent. `wr_done` rises in the cycle after the start edge, with `wr_err` = 1 and `wr_count` = 0.
- R8: A zero-length write sends no frame. `wr_done` rises in the cycle after the start edge, with `wr_err` = 0 and `wr_count` = 0.
- R9: At `wr_done`, `wr_count` is the total size of the chunks that finished (program done, and compare passed when verify is on). On success it equals `wr_len`.
- R10: A host byte passes only when `in_valid` and `in_ready` are both high. `in_ready` is never high while `sp_ready` is low. Each accepted host byte is sent as the next data byte.
- R11: `wr_done` is a one-cycle pulse during which `wr_busy` is low. `wr_busy` is high from the cycle after a launched start until the done cycle. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Request a write (taken when not busy) |
| wr_addr | input | AW | Byte address of the first byte |
| wr_len | input | LW | Number of bytes to write |
| wr_verify | input | 1 | Compare each page after programming |
| wr_busy | output | 1 | Write in progress |
| wr_done | output | 1 | One-cycle completion pulse |
| wr_err | output | 2 | 0 ok, 1 out of range, 2 compare mismatch |
| wr_count | output | LW | Bytes written, valid at done |
| in_valid | input | 1 | Host byte available |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Host byte taken this cycle if valid |
| sp_valid | output | 1 | Byte offered to the shifter |
| sp_byte | output | 8 | Byte to shift out |
| sp_end | output | 1 | Release chip select after this byte |
| sp_ready | input | 1 | Shifter exchanges the byte this cycle |
| sp_rx | input | 8 | Byte shifted in during the exchanged slot |

## Verification
The result of a rejected or zero-length request is due exactly one cycle after the start edge. The bench checks this by sampling `wr_done` at the first falling edge after that edge. A launched write completes only after the final status poll sees ready. So the bench waits for the done pulse at falling edges, and it checks the count, the error code, the flash contents and the frame tallies only then. The flash and shifter model answers every byte between edges, half a cycle ahead of the edge that exchanges it. The status byte is therefore already present when the poll slot is taken, and the model keeps the device busy for several polls, so repeated polling is exercised.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [2:0] {S_IDLE, S_NEXT, S_HDR, S_DATA, S_POLL_OP, S_POLL_RD} st_t;
  typedef enum logic [1:0] {K_LOAD, K_PROG, K_CMP} kind_t;

  localparam logic [7:0] OPC_LOAD = 8'h53;
  localparam logic [7:0] OPC_PROG = 8'h82;
  localparam logic [7:0] OPC_CMP  = 8'h60;
  localparam logic [7:0] OPC_STAT = 8'hD7;

  localparam int STAT_RDY  = 7;
  localparam int STAT_DIFF = 6;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_RANGE = 2'd1;
  localparam logic [1:0] ERR_CMP   = 2'd2;
endpackage

// File: rtl/pws_chunker.sv
module pws_chunker #(
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int NUM_PAGES  = 512,
  localparam int SIZE = PAGE_BYTES * NUM_PAGES,
  localparam int AW   = $clog2(SIZE),
  localparam int LW   = AW + 1,
  localparam int OW   = $clog2(PAGE_BYTES + 1),
  localparam int PW   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  input  logic          adv,
  output logic [OW-1:0] chunk,
  output logic          partial,
  output logic          last,
  output logic [23:0]   page_dev,
  output logic [23:0]   prog_dev
);
  logic [PW-1:0] page_q;
  logic [OW-1:0] offs_q;
  logic [LW-1:0] rem_q;
  logic [OW-1:0] room;

  always_comb begin
    room     = OW'(PAGE_BYTES) - offs_q;
    chunk    = (rem_q < LW'(room)) ? rem_q[OW-1:0] : room;
    partial  = (chunk != OW'(PAGE_BYTES));
    last     = (rem_q == LW'(chunk));
    page_dev = 24'(page_q) << PAGE_SHIFT;
    prog_dev = page_dev + 24'(offs_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      offs_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      page_q <= PW'(ld_addr / PAGE_BYTES);
      offs_q <= OW'(ld_addr % PAGE_BYTES);
      rem_q  <= ld_len;
    end else if (adv) begin
      page_q <= page_q + 1'b1;
      offs_q <= '0;
      rem_q  <= rem_q - LW'(chunk);
    end
  end

  // R2: a pending chunk is never empty and never crosses the page end
  p_chunk_fit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q != '0) |-> (chunk != '0 && (32'(offs_q) + 32'(chunk)) <= PAGE_BYTES));
endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int OW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          verify,
  input  logic [OW-1:0] chunk,
  input  logic          partial,
  input  logic          last,
  input  logic [23:0]   page_dev,
  input  logic [23:0]   prog_dev,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          sp_valid,
  output logic [7:0]    sp_byte,
  output logic          sp_end,
  input  logic          sp_ready,
  input  logic [7:0]    sp_rx,
  output logic          adv,
  output logic          fin,
  output logic          fin_cmp
);
  st_t           st;
  kind_t         kind;
  logic [1:0]    idx;
  logic [OW-1:0] dcnt;
  logic          verify_q;
  logic          xfer, rdy_seen, dlast;
  logic [23:0]   hdr_addr;

  always_comb begin
    sp_valid = (st == S_HDR) || (st == S_POLL_OP) || (st == S_POLL_RD) ||
               (st == S_DATA && in_valid);
    in_ready = (st == S_DATA) && sp_ready;
    xfer     = sp_valid && sp_ready;
    dlast    = (dcnt + OW'(1)) == chunk;
    hdr_addr = (kind == K_PROG) ? prog_dev : {page_dev[23:8], 8'h00};
    sp_byte  = 8'h00;
    sp_end   = 1'b0;
    unique case (st)
      S_HDR: begin
        unique case (idx)
          2'd0: sp_byte = (kind == K_LOAD) ? OPC_LOAD :
                          (kind == K_PROG) ? OPC_PROG : OPC_CMP;
          2'd1: sp_byte = hdr_addr[23:16];
          2'd2: sp_byte = hdr_addr[15:8];
          default: sp_byte = hdr_addr[7:0];
        endcase
        sp_end = (idx == 2'd3) && (kind != K_PROG);
      end
      S_DATA:    begin sp_byte = in_data;  sp_end = dlast; end
      S_POLL_OP: sp_byte = OPC_STAT;
      S_POLL_RD: sp_end = 1'b1;
      default: ;
    endcase
    rdy_seen = (st == S_POLL_RD) && xfer && sp_rx[STAT_RDY];
    fin_cmp  = rdy_seen && (kind == K_CMP) && sp_rx[STAT_DIFF];
    adv      = rdy_seen && (((kind == K_PROG) && !verify_q) ||
                            ((kind == K_CMP) && !sp_rx[STAT_DIFF]));
    fin      = fin_cmp || (adv && last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_PROG;
      idx      <= '0;
      dcnt     <= '0;
      verify_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (launch) begin
          st       <= S_NEXT;
          verify_q <= verify;
        end
        S_NEXT: begin
          kind <= partial ? K_LOAD : K_PROG;
          idx  <= '0;
          st   <= S_HDR;
        end
        S_HDR: if (xfer) begin
          idx <= idx + 1'b1;
          if (idx == 2'd3) begin
            dcnt <= '0;
            st   <= (kind == K_PROG) ? S_DATA : S_POLL_OP;
          end
        end
        S_DATA: if (xfer) begin
          dcnt <= dcnt + 1'b1;
          if (dlast) st <= S_POLL_OP;
        end
        S_POLL_OP: if (xfer) st <= S_POLL_RD;
        S_POLL_RD: if (xfer) begin
          if (!sp_rx[STAT_RDY]) st <= S_POLL_OP;
          else if (fin) st <= S_IDLE;
          else if (adv) st <= S_NEXT;
          else begin
            kind <= (kind == K_LOAD) ? K_PROG : K_CMP;
            idx  <= '0;
            st   <= S_HDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: a busy status sends the block back to another status frame
  p_poll_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL_RD && xfer && !sp_rx[STAT_RDY]) |=> (st == S_POLL_OP));
  // R6: a compare mismatch ends the sequence
  p_cmp_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL_RD && xfer && sp_rx[STAT_RDY] && sp_rx[STAT_DIFF] && kind == K_CMP)
    |=> (st == S_IDLE));
  // R4: a command byte held back by the shifter stays put
  p_hdr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_valid && !sp_ready && st != S_DATA) |=> (sp_valid && $stable(sp_byte)));
endmodule

// File: rtl/pws_page_writer.sv
module pws_page_writer
  import pws_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int NUM_PAGES  = 512,
  localparam int SIZE = PAGE_BYTES * NUM_PAGES,
  localparam int AW   = $clog2(SIZE),
  localparam int LW   = AW + 1,
  localparam int OW   = $clog2(PAGE_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic [AW-1:0] wr_addr,
  input  logic [LW-1:0] wr_len,
  input  logic          wr_verify,
  output logic          wr_busy,
  output logic          wr_done,
  output logic [1:0]    wr_err,
  output logic [LW-1:0] wr_count,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          sp_valid,
  output logic [7:0]    sp_byte,
  output logic          sp_end,
  input  logic          sp_ready,
  input  logic [7:0]    sp_rx
);
  logic          busy_q, done_q;
  logic [1:0]    err_q;
  logic [LW-1:0] count_q;
  logic [LW:0]   end_sum;
  logic          fits, accept, launch;
  logic [OW-1:0] chunk;
  logic          partial, last, adv, fin, fin_cmp;
  logic [23:0]   page_dev, prog_dev;

  always_comb begin
    end_sum = (LW+1)'(wr_addr) + (LW+1)'(wr_len);
    fits    = end_sum <= (LW+1)'(SIZE);
    accept  = wr_start && !busy_q;
    launch  = accept && fits && (wr_len != '0);
  end

  pws_chunker #(.PAGE_BYTES(PAGE_BYTES), .PAGE_SHIFT(PAGE_SHIFT), .NUM_PAGES(NUM_PAGES)) u_chunk (
    .clk(clk), .rst_n(rst_n), .load(launch), .ld_addr(wr_addr), .ld_len(wr_len),
    .adv(adv), .chunk(chunk), .partial(partial), .last(last),
    .page_dev(page_dev), .prog_dev(prog_dev)
  );

  pws_ctrl #(.OW(OW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .launch(launch), .verify(wr_verify),
    .chunk(chunk), .partial(partial), .last(last),
    .page_dev(page_dev), .prog_dev(prog_dev),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sp_valid(sp_valid), .sp_byte(sp_byte), .sp_end(sp_end),
    .sp_ready(sp_ready), .sp_rx(sp_rx),
    .adv(adv), .fin(fin), .fin_cmp(fin_cmp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= ERR_NONE;
      count_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept && !launch) begin
        done_q  <= 1'b1;
        err_q   <= fits ? ERR_NONE : ERR_RANGE;
        count_q <= '0;
      end else if (launch) begin
        busy_q  <= 1'b1;
        err_q   <= ERR_NONE;
        count_q <= '0;
      end
      if (adv) count_q <= count_q + LW'(chunk);
      if (fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= fin_cmp ? ERR_CMP : ERR_NONE;
      end
    end
  end

  assign wr_busy  = busy_q;
  assign wr_done  = done_q;
  assign wr_err   = err_q;
  assign wr_count = count_q;

  // R11: completion is never reported while still busy
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> !wr_busy);
  // R7: a rejected range reports nothing written
  p_range_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && wr_err == ERR_RANGE) |-> (wr_count == '0));
endmodule

// File: tb/tb_pws_page_writer.sv
module tb_pws_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int PB  = 12;
  localparam int PSH = 8;
  localparam int NP  = 8;
  localparam int SIZE = PB * NP;
  localparam int AW = $clog2(SIZE);
  localparam int LW = AW + 1;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] len;
    logic       verify;
    logic       stall;
    logic [3:0] n_load;
    logic [3:0] n_prog;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd0,  8'd12, 1'b0, 1'b0, 4'd0, 4'd1},
    '{8'd5,  8'd3,  1'b0, 1'b1, 4'd1, 4'd1},
    '{8'd7,  8'd20, 1'b1, 1'b0, 4'd2, 4'd3},
    '{8'd24, 8'd36, 1'b1, 1'b1, 4'd0, 4'd3},
    '{8'd90, 8'd6,  1'b0, 1'b0, 4'd1, 4'd1},
    '{8'd95, 8'd1,  1'b1, 1'b1, 4'd1, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_start = 1'b0, wr_verify = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [LW-1:0] wr_len = '0;
  logic wr_busy, wr_done;
  logic [1:0] wr_err;
  logic [LW-1:0] wr_count;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00;
  logic sp_valid, sp_end, sp_ready = 1'b0;
  logic [7:0] sp_byte, sp_rx = 8'h00;

  pws_page_writer #(.PAGE_BYTES(PB), .PAGE_SHIFT(PSH), .NUM_PAGES(NP)) dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr), .wr_len(wr_len),
    .wr_verify(wr_verify), .wr_busy(wr_busy), .wr_done(wr_done), .wr_err(wr_err),
    .wr_count(wr_count), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sp_valid(sp_valid), .sp_byte(sp_byte), .sp_end(sp_end), .sp_ready(sp_ready),
    .sp_rx(sp_rx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] flash [NP][PB];
  logic [7:0] shadow [NP][PB];
  logic [7:0] bufm [PB];
  logic [7:0] m_op = 8'h00;
  logic [23:0] m_a = '0;
  int m_idx = 0, busy_left = 0, n_load = 0, n_prog = 0, n_cmp = 0, proto = 0;
  int hs_viol = 0, inject_pg = -1, ptr = 0, cur_seed = 0, cyc = 0;
  logic diff = 1'b0, stall_mode = 1'b0;

  function automatic logic [7:0] srcb(int seed, int i);
    return 8'(seed * 29 + i * 7 + 3);
  endfunction

  task automatic chk(string req, logic ok, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flash and shifter model: answers each byte half a cycle before its edge
  task automatic model_byte(input logic [7:0] b, input logic e);
    int pg, off;
    if (m_idx == 0) begin
      m_op = b;
      if (b != 8'hD7 && busy_left != 0) proto++;   // R5: command while busy
    end else if (m_idx <= 3) m_a = {m_a[15:0], b};
    else if (m_op == 8'h82) begin
      off = int'(m_a[7:0]) + m_idx - 4;
      if (off < PB) bufm[off] = b; else proto++;
    end else proto++;
    if (m_op == 8'hD7 && m_idx == 1) begin
      sp_rx = {(busy_left == 0), diff, 6'b0};
      if (busy_left != 0) busy_left--;
    end
    if (e) begin
      pg = int'(m_a[23:8]);
      case (m_op)
        8'h53: if (m_idx != 3 || m_a[7:0] != 8'h00 || pg >= NP) proto++;
               else begin
                 for (int o = 0; o < PB; o++) bufm[o] = flash[pg][o];
                 n_load++; busy_left = 2;
               end
        8'h82: if (m_idx < 4 || pg >= NP) proto++;
               else begin
                 for (int o = 0; o < PB; o++) flash[pg][o] = bufm[o];
                 if (pg == inject_pg) flash[pg][0] = ~flash[pg][0];
                 n_prog++; busy_left = 3;
               end
        8'h60: if (m_idx != 3 || m_a[7:0] != 8'h00 || pg >= NP) proto++;
               else begin
                 diff = 1'b0;
                 for (int o = 0; o < PB; o++) if (bufm[o] != flash[pg][o]) diff = 1'b1;
                 n_cmp++; busy_left = 1;
               end
        8'hD7: if (m_idx != 1) proto++;
        default: proto++;
      endcase
      m_idx = 0;
    end else m_idx++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (stall_mode) begin
      sp_ready = (cyc % 4) != 3;
      in_valid = (cyc % 3) != 1;
    end else begin
      sp_ready = 1'b1;
      in_valid = 1'b1;
    end
    in_data = srcb(cur_seed, ptr);
    #1;
    if (in_ready && !sp_ready) hs_viol++;
    if (in_valid && in_ready) ptr++;
    sp_rx = 8'h00;
    if (rst_n && sp_valid && sp_ready) model_byte(sp_byte, sp_end);
  end

  int lat;
  task automatic do_write(int addr, int len, logic ver, logic stl, int seed, logic poke);
    int a;
    @(negedge clk);
    for (int p = 0; p < NP; p++) for (int o = 0; o < PB; o++) shadow[p][o] = flash[p][o];
    if (addr + len <= SIZE)
      for (int i = 0; i < len; i++) begin
        a = addr + i;
        shadow[a / PB][a % PB] = srcb(seed, i);
      end
    n_load = 0; n_prog = 0; n_cmp = 0; proto = 0; ptr = 0;
    cur_seed = seed; stall_mode = stl;
    wr_addr = AW'(addr); wr_len = LW'(len); wr_verify = ver; wr_start = 1'b1;
    @(negedge clk);
    wr_start = 1'b0;
    lat = 1;
    while (!wr_done && lat < 4000) begin
      if (poke && lat == 3) begin
        wr_addr = '0; wr_len = LW'(5); wr_start = 1'b1;
      end
      @(negedge clk);
      wr_start = 1'b0;
      lat++;
    end
    if (!wr_done) begin
      fails++; tests++;
      $display("FAIL R11 actual=no_done expected=done");
    end
  endtask

  function automatic int mismatches();
    int n = 0;
    for (int p = 0; p < NP; p++) for (int o = 0; o < PB; o++)
      if (flash[p][o] !== shadow[p][o]) n++;
    return n;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) for (int o = 0; o < PB; o++) flash[p][o] = 8'(p * 16 + o + 64);
    for (int o = 0; o < PB; o++) bufm[o] = 8'hEE;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 busy", wr_busy == 1'b0, wr_busy, 0);
    chk("R1 done", wr_done == 1'b0, wr_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp_valid", sp_valid == 1'b0, sp_valid, 0);
    chk("R1 in_ready", in_ready == 1'b0, in_ready, 0);

    for (int v = 0; v < NV; v++) begin
      do_write(int'(VECS[v].addr), int'(VECS[v].len), VECS[v].verify, VECS[v].stall, v + 1, 1'b0);
      chk("R9 err", wr_err == 2'd0, wr_err, 0);
      chk("R9 count", wr_count == LW'(VECS[v].len), wr_count, VECS[v].len);
      chk("R3 loads", n_load == int'(VECS[v].n_load), n_load, VECS[v].n_load);
      chk("R2 programs", n_prog == int'(VECS[v].n_prog), n_prog, VECS[v].n_prog);
      chk("R6 compares", n_cmp == (VECS[v].verify ? int'(VECS[v].n_prog) : 0), n_cmp,
          VECS[v].verify ? VECS[v].n_prog : 0);
      chk("R4 contents", mismatches() == 0, mismatches(), 0);   // R2 R3 R4 R10
      chk("R5 protocol", proto == 0, proto, 0);
      @(negedge clk);
      chk("R11 pulse", wr_done == 1'b0, wr_done, 0);
    end

    // R8: zero length
    do_write(10, 0, 1'b0, 1'b0, 20, 1'b0);
    chk("R8 latency", lat == 1, lat, 1);
    chk("R8 err", wr_err == 2'd0, wr_err, 0);
    chk("R8 count", wr_count == '0, wr_count, 0);
    chk("R8 frames", n_load + n_prog + n_cmp == 0, n_load + n_prog + n_cmp, 0);

    // R7: end beyond device size
    do_write(90, 7, 1'b0, 1'b0, 21, 1'b0);
    chk("R7 latency", lat == 1, lat, 1);
    chk("R7 err", wr_err == 2'd1, wr_err, 1);
    chk("R7 count", wr_count == '0, wr_count, 0);
    chk("R7 frames", n_load + n_prog + n_cmp == 0, n_load + n_prog + n_cmp, 0);
    chk("R7 contents", mismatches() == 0, mismatches(), 0);

    // R11: start while busy is ignored
    do_write(48, 12, 1'b0, 1'b1, 22, 1'b1);
    chk("R11 count", wr_count == LW'(12), wr_count, 12);
    chk("R11 programs", n_prog == 1, n_prog, 1);
    chk("R11 contents", mismatches() == 0, mismatches(), 0);

    // R11: busy seen during a write
    @(negedge clk);
    wr_addr = AW'(60); wr_len = LW'(4); wr_verify = 1'b0; wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
    @(negedge clk);
    chk("R11 busy", wr_busy == 1'b1, wr_busy, 1);
    lat = 0;
    while (!wr_done && lat < 4000) begin @(negedge clk); lat++; end
    chk("R11 done", wr_done == 1'b1, wr_done, 1);

    // R6: compare mismatch on the second page stops the write
    inject_pg = 1;
    do_write(0, 30, 1'b1, 1'b0, 23, 1'b0);
    chk("R6 err", wr_err == 2'd2, wr_err, 2);
    chk("R6 count", wr_count == LW'(12), wr_count, 12);   // R9: only the first page counted
    chk("R6 programs", n_prog == 2, n_prog, 2);
    chk("R6 compares", n_cmp == 2, n_cmp, 2);
    inject_pg = -1;

    // R10: host handshake never runs ahead of the shifter
    chk("R10 handshake", hs_viol == 0, hs_viol, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule